// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a fully associative buffer of page-to-frame translations. Each slot holds an address-space identifier, a virtual page number, a physical frame number, a valid bit and a wired bit. A lookup presents a page number together with the identifier of the running address space. Every slot compares both keys at once. One cycle later the block reports a hit with the stored frame and the slot index, or it reports a miss. A lookup is a hit only when both keys match.

After a miss, the surrounding walker reads the page table and installs the result through the fill port. The fill chooses its slot in this order:
- the slot that already holds the same page and identifier;
- otherwise the lowest-numbered empty slot;
- otherwise the least recently used slot that is not wired.

When every slot is valid and wired, the fill is dropped and a one-cycle rejection flag is raised. A flush command empties every slot that is not wired, so that stale translations cannot be used after a context switch.

Only one command acts in a cycle. Flush has the highest priority, then fill, then lookup. The response path is a small state machine with four states:
- `RS_IDLE`: nothing to report.
- `RS_HIT`: lookup hit; frame and slot are shown.
- `RS_MISS`: lookup miss.
- `RS_REJECT`: a fill was dropped.

The transitions, taken at every clock edge:
- a lookup that hits goes to `RS_HIT`;
- a lookup that misses goes to `RS_MISS`;
- a rejected fill goes to `RS_REJECT`;
- an accepted fill, a flush or no command goes to `RS_IDLE`.

A state lasts exactly one cycle unless the next command leads to it again. Synchronous reset goes to `RS_IDLE`.

Top module: `asid_tlb`

## Requirements
- R1: A lookup applied at a clock edge gives, after that edge, `rsp_valid`=1 for one cycle. On a hit it also gives `rsp_hit`=1, the stored frame on `rsp_pfn` and the slot index on `rsp_slot`. On a miss `rsp_hit`, `rsp_pfn` and `rsp_slot` are all 0.
- R2: A lookup whose page number matches a valid slot but whose address-space identifier differs is a miss.
- R3: After an accepted fill, a lookup with the same keys hits and returns the filled frame. A fill whose keys are already present rewrites that slot's frame and wired bit, and creates no second copy.
- R4: A fill with new keys goes to the lowest-index empty slot while any slot is empty.
- R5: When no slot is empty, a fill with new keys replaces the valid non-wired slot that was least recently touched. Both lookup hits and fills count as touches.
- R6: A slot that is valid and wired is never chosen for replacement.
- R7: A flush empties every non-wired slot and leaves wired slots valid and unchanged.
- R8: If every slot is valid and wired and the fill keys are not present, the fill has no effect. `fill_rejected` is 1 for the single cycle after that edge.
- R9: In one cycle, flush overrides fill and lookup, and fill overrides lookup. An overridden command has no effect, and a lookup that was overridden gives no response.
- R10: After reset every slot is empty. `rsp_valid` and `fill_rejected` are 0 until a command produces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Lookup command |
| lookup_asid | input | ASID_W | Identifier of the current address space |
| lookup_vpn | input | VPN_W | Page number to translate |
| fill_valid | input | 1 | Install command |
| fill_asid | input | ASID_W | Identifier of the translation being installed |
| fill_vpn | input | VPN_W | Page number being installed |
| fill_pfn | input | PFN_W | Frame number being installed |
| fill_wired | input | 1 | Exempts the installed slot from replacement and flush |
| flush | input | 1 | Empties every non-wired slot |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on a hit, else 0 |
| rsp_slot | output | IDX_W | Slot index on a hit, else 0 |
| fill_rejected | output | 1 | Previous fill was dropped because every slot was wired |

## Verification
The properties assume that the command inputs are known values at every edge after reset. They also assume that a slot's wired bit is cleared whenever the slot is empty: reset clears it, and neither a flush nor an eviction ever empties a wired slot, so the no-duplicate and all-wired rejection checks can rely on it. The stimulus meets the first assumption by holding all commands low between operations. It changes inputs only on falling edges and, in its mixed-command cases, drives known values on every input. The bench runs against a four-slot instance and decides hits from a timestamp model. Its key space is small enough that duplicates, full buffers, all-wired buffers and flushes all occur many times.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOOKUP,
        OP_FILL,
        OP_FLUSH
    } tlb_op_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_REJECT
    } rsp_state_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
    input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
    input  logic [ASID_W-1:0]  key_asid,
    input  logic [VPN_W-1:0]   key_vpn,
    output logic [ENTRIES-1:0] match_vec,
    output logic               match_any,
    output logic [IDX_W-1:0]   match_idx
);

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = ent_valid[g]
                                  && (ent_vpn[g] == key_vpn)
                                  && (ent_asid[g] == key_asid);
        end
    endgenerate

    assign match_any = |match_vec;

    // keys are unique, so at most one bit is set and an OR encoder suffices
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                match_idx = match_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] ent_wired,
    input  logic [IDX_W-1:0]   ent_age [ENTRIES],
    output logic               empty_any,
    output logic [IDX_W-1:0]   empty_idx,
    output logic               lru_any,
    output logic [IDX_W-1:0]   lru_idx
);

    logic [IDX_W-1:0] best_age;

    // walk downward so the last assignment is the lowest free index
    always_comb begin
        empty_any = 1'b0;
        empty_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                empty_any = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
    end

    // oldest rank among replaceable slots
    always_comb begin
        lru_any  = 1'b0;
        lru_idx  = '0;
        best_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && !ent_wired[i]
                && (!lru_any || ent_age[i] > best_age)) begin
                lru_any  = 1'b1;
                lru_idx  = IDX_W'(i);
                best_age = ent_age[i];
            end
        end
    end

endmodule

// File: rtl/tlb_resp_fsm.sv
module tlb_resp_fsm
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  tlb_op_t          op,
    input  logic             lk_hit,
    input  logic             fill_drop,
    input  logic [PFN_W-1:0] hit_pfn,
    input  logic [IDX_W-1:0] hit_idx,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [IDX_W-1:0] rsp_slot,
    output logic             fill_rejected
);

    rsp_state_t       state_q, state_d;
    logic [PFN_W-1:0] pfn_q;
    logic [IDX_W-1:0] slot_q;

    always_comb begin
        unique case (op)
            OP_LOOKUP: state_d = lk_hit ? RS_HIT : RS_MISS;
            OP_FILL:   state_d = fill_drop ? RS_REJECT : RS_IDLE;
            OP_FLUSH:  state_d = RS_IDLE;
            OP_NONE:   state_d = RS_IDLE;
            default:   state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            pfn_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (op == OP_LOOKUP && lk_hit) begin
                pfn_q  <= hit_pfn;
                slot_q <= hit_idx;
            end
        end
    end

    always_comb begin
        rsp_valid     = 1'b0;
        rsp_hit       = 1'b0;
        rsp_pfn       = '0;
        rsp_slot      = '0;
        fill_rejected = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
            end
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pfn   = pfn_q;
                rsp_slot  = slot_q;
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
            end
            RS_REJECT: begin
                fill_rejected = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_valid,
    input  logic [ASID_W-1:0] lookup_asid,
    input  logic [VPN_W-1:0]  lookup_vpn,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_wired,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [IDX_W-1:0]  rsp_slot,
    output logic              fill_rejected
);

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_wired;
    logic [ASID_W-1:0]  ent_asid [ENTRIES];
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [IDX_W-1:0]   ent_age  [ENTRIES];

    tlb_op_t op;

    always_comb begin
        if (flush)             op = OP_FLUSH;
        else if (fill_valid)   op = OP_FILL;
        else if (lookup_valid) op = OP_LOOKUP;
        else                   op = OP_NONE;
    end

    logic [ENTRIES-1:0] lk_vec, fm_vec;
    logic               lk_hit, fm_any;
    logic [IDX_W-1:0]   lk_idx, fm_idx;

    tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lookup_cmp (
        .ent_valid (ent_valid),
        .ent_asid  (ent_asid),
        .ent_vpn   (ent_vpn),
        .key_asid  (lookup_asid),
        .key_vpn   (lookup_vpn),
        .match_vec (lk_vec),
        .match_any (lk_hit),
        .match_idx (lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fill_cmp (
        .ent_valid (ent_valid),
        .ent_asid  (ent_asid),
        .ent_vpn   (ent_vpn),
        .key_asid  (fill_asid),
        .key_vpn   (fill_vpn),
        .match_vec (fm_vec),
        .match_any (fm_any),
        .match_idx (fm_idx)
    );

    logic             empty_any, lru_any;
    logic [IDX_W-1:0] empty_idx, lru_idx;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .ent_valid (ent_valid),
        .ent_wired (ent_wired),
        .ent_age   (ent_age),
        .empty_any (empty_any),
        .empty_idx (empty_idx),
        .lru_any   (lru_any),
        .lru_idx   (lru_idx)
    );

    logic             fill_ok;
    logic [IDX_W-1:0] fill_slot;

    always_comb begin
        fill_ok   = 1'b1;
        fill_slot = '0;
        if (fm_any)         fill_slot = fm_idx;
        else if (empty_any) fill_slot = empty_idx;
        else if (lru_any)   fill_slot = lru_idx;
        else                fill_ok   = 1'b0;
    end

    logic             do_fill, touch_en;
    logic [IDX_W-1:0] touch_idx;

    assign do_fill   = (op == OP_FILL) && fill_ok;
    assign touch_en  = do_fill || ((op == OP_LOOKUP) && lk_hit);
    assign touch_idx = (op == OP_FILL) ? fill_slot : lk_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_valid[i] <= 1'b0;
                ent_wired[i] <= 1'b0;
                ent_asid[i]  <= '0;
                ent_vpn[i]   <= '0;
                ent_pfn[i]   <= '0;
                ent_age[i]   <= IDX_W'(i);
            end
        end else begin
            if (op == OP_FLUSH) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (!ent_wired[i]) ent_valid[i] <= 1'b0;
                end
            end
            if (do_fill) begin
                ent_valid[fill_slot] <= 1'b1;
                ent_wired[fill_slot] <= fill_wired;
                ent_asid[fill_slot]  <= fill_asid;
                ent_vpn[fill_slot]   <= fill_vpn;
                ent_pfn[fill_slot]   <= fill_pfn;
            end
            // recency ranks: 0 is newest, ranks stay a permutation
            if (touch_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == touch_idx) begin
                        ent_age[i] <= '0;
                    end else if (ent_age[i] < ent_age[touch_idx]) begin
                        ent_age[i] <= ent_age[i] + 1'b1;
                    end
                end
            end
        end
    end

    tlb_resp_fsm #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_resp (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .lk_hit        (lk_hit),
        .fill_drop     (!fill_ok),
        .hit_pfn       (ent_pfn[lk_idx]),
        .hit_idx       (lk_idx),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_pfn       (rsp_pfn),
        .rsp_slot      (rsp_slot),
        .fill_rejected (fill_rejected)
    );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               lookup_valid,
    input logic               fill_valid,
    input logic               flush,
    input logic               rsp_valid,
    input logic               fill_rejected,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ent_wired
);

    // R1: an unopposed lookup always answers next cycle
    a_r1_lookup_answers: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && !fill_valid && !flush) |=> rsp_valid);

    // R10: no response appears without a lookup that won arbitration
    a_r10_no_stray_resp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lookup_valid && !fill_valid && !flush));

    // R9: a flush silences both response outputs
    a_r9_flush_wins: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!rsp_valid && !fill_rejected));

    // R8: rejection only follows a fill when every slot was valid and wired
    a_r8_reject_cause: assert property (@(posedge clk) disable iff (rst)
        fill_rejected |-> $past(fill_valid && !flush && (&(ent_valid & ent_wired))));

    // R3: keys never duplicate, so the lookup compare is one-hot or zero
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_wired
            // R6 and R7: a wired slot stays valid across eviction and flush
            a_r6_wired_kept: assert property (@(posedge clk) disable iff (rst)
                (ent_valid[g] && ent_wired[g]) |=> ent_valid[g]);
        end
    endgenerate

endmodule

bind asid_tlb tlb_checker #(.ENTRIES(ENTRIES)) u_check (
    .clk           (clk),
    .rst           (rst),
    .lookup_valid  (lookup_valid),
    .fill_valid    (fill_valid),
    .flush         (flush),
    .rsp_valid     (rsp_valid),
    .fill_rejected (fill_rejected),
    .hit_vec       (lk_vec),
    .ent_valid     (ent_valid),
    .ent_wired     (ent_wired)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;

    localparam int N  = 4;
    localparam int AW = 2;
    localparam int VW = 4;
    localparam int PW = 6;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          lookup_valid, fill_valid, fill_wired, flush;
    logic [AW-1:0] lookup_asid, fill_asid;
    logic [VW-1:0] lookup_vpn, fill_vpn;
    logic [PW-1:0] fill_pfn;
    logic          rsp_valid, rsp_hit, fill_rejected;
    logic [PW-1:0] rsp_pfn;
    logic [IW-1:0] rsp_slot;

    always #10 clk = ~clk;

    asid_tlb #(.ENTRIES(N), .ASID_W(AW), .VPN_W(VW), .PFN_W(PW)) uut (
        .clk(clk), .rst(rst),
        .lookup_valid(lookup_valid), .lookup_asid(lookup_asid), .lookup_vpn(lookup_vpn),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_wired(fill_wired), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .rsp_slot(rsp_slot), .fill_rejected(fill_rejected)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // timestamp model: slot with the oldest touch time is least recent
    bit mv [N];
    bit mw [N];
    int ma [N];
    int mk [N];
    int mp [N];
    int ms [N];
    int tnow;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mw[i] = 0; ma[i] = 0; mk[i] = 0; mp[i] = 0; ms[i] = 0;
        end
        tnow = 0;
    endtask

    task automatic drive_idle();
        lookup_valid = 0; fill_valid = 0; flush = 0; fill_wired = 0;
        lookup_asid = '0; lookup_vpn = '0;
        fill_asid = '0; fill_vpn = '0; fill_pfn = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive_idle();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    // one cycle of any command mix; expectation follows flush > fill > lookup
    task automatic step(input bit lk, input bit fi, input bit fl,
                        input int a, input int v, input int p, input bit w,
                        input string tag);
        bit e_valid, e_hit, e_rej;
        int e_pfn, e_slot, slot;
        @(negedge clk);
        lookup_valid = lk; fill_valid = fi; flush = fl; fill_wired = w;
        lookup_asid = AW'(a); lookup_vpn = VW'(v);
        fill_asid = AW'(a); fill_vpn = VW'(v); fill_pfn = PW'(p);
        e_valid = 0; e_hit = 0; e_rej = 0; e_pfn = 0; e_slot = 0;
        if (fl) begin
            for (int i = 0; i < N; i++) if (!mw[i]) mv[i] = 0;
        end else if (fi) begin
            slot = -1;
            for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a && mk[i] == v) slot = i;
            if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
            if (slot < 0) begin
                for (int i = 0; i < N; i++)
                    if (mv[i] && !mw[i] && (slot < 0 || ms[i] < ms[slot])) slot = i;
            end
            if (slot < 0) e_rej = 1;
            else begin
                mv[slot] = 1; mw[slot] = w; ma[slot] = a; mk[slot] = v; mp[slot] = p;
                tnow++; ms[slot] = tnow;
            end
        end else if (lk) begin
            e_valid = 1;
            for (int i = 0; i < N; i++) begin
                if (mv[i] && ma[i] == a && mk[i] == v) begin
                    e_hit = 1; e_pfn = mp[i]; e_slot = i;
                    tnow++; ms[i] = tnow;
                end
            end
        end
        @(negedge clk);
        check({tag, " rsp_valid"}, int'(rsp_valid), int'(e_valid));
        check({tag, " rsp_hit"}, int'(rsp_hit), int'(e_hit));
        check({tag, " rsp_pfn"}, int'(rsp_pfn), e_pfn);
        check({tag, " rsp_slot"}, int'(rsp_slot), e_slot);
        check({tag, " fill_rejected"}, int'(fill_rejected), int'(e_rej));
        drive_idle();
    endtask

    task automatic lookup(input int a, input int v, input string tag);
        step(1, 0, 0, a, v, 0, 0, tag);
    endtask

    task automatic fill(input int a, input int v, input int p, input bit w, input string tag);
        step(0, 1, 0, a, v, p, w, tag);
    endtask

    task automatic do_flush(input string tag);
        step(0, 0, 1, 0, 0, 0, 0, tag);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        drive_idle();
        rst = 1;
        model_clear();
        do_reset();

        // R10: quiet outputs after reset, buffer empty
        check("R10 rsp_valid after reset", int'(rsp_valid), 0);
        check("R10 fill_rejected after reset", int'(fill_rejected), 0);
        for (int a = 0; a < 4; a++) for (int v = 0; v < 16; v++) lookup(a, v, "R10 empty miss");

        // R4: empty buffer fills slots 0..3 in order; R1 and R3 hits afterwards
        fill(1, 3, 10, 0, "R4 fill");
        fill(1, 4, 11, 0, "R4 fill");
        fill(2, 3, 12, 0, "R4 fill");
        fill(0, 7, 13, 0, "R4 fill");
        lookup(1, 3, "R1 slot0");
        lookup(1, 4, "R1 slot1");
        lookup(2, 3, "R1 slot2");
        lookup(0, 7, "R1 slot3");
        // R2: page matches but identifier differs
        lookup(3, 3, "R2 asid mismatch");
        lookup(0, 3, "R2 asid mismatch");
        // R1 R2 near-exhaustive key sweep
        for (int a = 0; a < 4; a++) for (int v = 0; v < 16; v++) lookup(a, v, "R1 R2 sweep");

        // R3: overwrite in place, no duplicate, other slots survive
        fill(1, 4, 33, 0, "R3 overwrite");
        lookup(1, 4, "R3 new frame");
        lookup(1, 3, "R3 others kept");
        lookup(0, 7, "R3 others kept");

        // R5: touch slot 2, then new keys evict least recent
        lookup(2, 3, "R5 touch");
        fill(3, 9, 20, 0, "R5 evict");
        fill(3, 10, 21, 0, "R5 evict");
        for (int a = 0; a < 4; a++) for (int v = 0; v < 16; v++) lookup(a, v, "R5 after evict");

        // R6: wired oldest slot is skipped by replacement
        do_reset();
        fill(0, 1, 1, 1, "R6 wired fill");
        fill(0, 2, 2, 0, "R6 fill");
        fill(0, 3, 3, 0, "R6 fill");
        fill(0, 4, 4, 0, "R6 fill");
        for (int k = 5; k < 10; k++) fill(1, k, k, 0, "R6 churn");
        lookup(0, 1, "R6 wired survives");

        // R7: flush keeps wired, empties the rest
        do_flush("R7 flush");
        lookup(0, 1, "R7 wired kept");
        for (int k = 5; k < 10; k++) lookup(1, k, "R7 flushed");
        // R4: after flush the lowest empty slot is 1
        fill(2, 2, 40, 0, "R4 after flush");
        lookup(2, 2, "R4 slot1");

        // R8: all wired rejects new keys
        do_reset();
        for (int k = 0; k < 4; k++) fill(1, k, 50 + k, 1, "R8 wired fill");
        fill(1, 9, 60, 0, "R8 rejected");
        lookup(1, 9, "R8 dropped");
        fill(1, 2, 61, 1, "R3 overwrite all wired");
        lookup(1, 2, "R3 overwrite all wired");
        do_flush("R7 all wired flush");
        for (int k = 0; k < 4; k++) lookup(1, k, "R7 wired kept");

        // R9: arbitration among simultaneous commands
        do_reset();
        fill(0, 5, 5, 0, "R9 setup");
        step(1, 1, 1, 0, 6, 7, 0, "R9 flush beats fill");
        lookup(0, 5, "R9 flushed");
        lookup(0, 6, "R9 fill ignored");
        step(1, 1, 0, 1, 6, 8, 0, "R9 fill beats lookup");
        lookup(1, 6, "R9 fill done");

        // pseudo-random sweep against the model
        r = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            int sel, a, v;
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            if (n % 300 == 0) do_reset();
            sel = int'(r[3:0]);
            a = int'(r[7]);
            v = int'(r[10:9]);
            if (sel < 8)       lookup(a, v, "R1 R5 sweep lookup");
            else if (sel < 15) fill(a, v, int'(r[15:11]), (r[6:4] == 3'd0), "R3 R5 R8 sweep fill");
            else               do_flush("R7 sweep flush");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule